// File: doc/BRIEF.md
# Depth-Tested Fragment Back End

This block is the last stage of a rasterizer. It takes one fragment at a time from a valid/ready stream. Each fragment carries a pixel position, a depth, a base colour, an alpha value and a blend mode bit. The filtered texel colour for the fragment arrives on a side input in the same cycle as the fragment.

The block first reads the stored depth for the pixel. A fragment that is not strictly nearer than the stored depth is discarded. A nearer fragment writes its depth back at once. Its colour is then modulated by the texel. When the blend mode bit is set, a fragment with zero alpha is dropped at this point. A surviving blending fragment reads the destination colour, mixes it with its own colour by alpha, and writes the result. When the blend mode bit is clear, the fragment skips the alpha test and the destination read, and writes its modulated colour directly.

Depth and colour memories are reached through simple synchronous ports that are external to the block. Read data returns one cycle after the read strobe, and writes take effect at the clock edge. Fragments that target different pixels enter at one per clock. A fragment whose pixel is still in flight is held back through the ready signal.

Top module: `frag_backend`

Structure and timing:
- Stages: accept (the depth read is issued) → Z stage (compare and depth write) → shade stage (alpha test and destination read) → write stage (colour write).
- The write stage holds a fate state: `FATE_NONE` (idle) → `FATE_OPAQUE` or `FATE_BLEND` on entry → back to `FATE_NONE` after one cycle.
- The pixel address is `{y, x}`.
- Each colour word is `{r, g, b}` with r in the top channel.

## Requirements
- R1: After reset, no depth or colour write occurs until a fragment is accepted, and `in_ready` is high.
- R2: In the accept cycle, a depth read is issued for address `{y,x}`. One cycle later, if the fragment depth is strictly smaller than the stored depth, the fragment depth is written to that address.
- R3: A fragment whose depth is equal to or greater than the stored depth produces no depth write and no colour write.
- R4: The textured colour of each 8-bit channel is `(base*texel + 127)/255`.
- R5: With the blend bit at 0, the alpha value is ignored, no colour read is made, and the textured colour is written to the pixel three cycles after acceptance.
- R6: With the blend bit at 1 and alpha equal to 0, a passing fragment still writes its depth but produces no colour write.
- R7: With the blend bit at 1 and alpha nonzero, each channel of the written colour is `(src*a + dst*(255-a) + 127)/255`. Here `dst` is the colour read from the pixel one cycle before the write.
- R8: Fragments for distinct pixels are accepted on consecutive clocks. While an earlier fragment for the same pixel is past acceptance but has not finished, `in_ready` is low. With no other traffic, a same-pixel follower is therefore accepted four cycles after its predecessor.
- R9: Every accepted fragment is neither lost nor duplicated. Writes to one pixel land in arrival order, so a later fragment is depth-tested against the result of the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fragment present |
| in_ready | output | 1 | Fragment accepted this cycle if valid |
| in_x | input | XW | Pixel column |
| in_y | input | YW | Pixel row |
| in_z | input | ZW | Fragment depth, smaller is nearer |
| in_rgb | input | 3*CW | Base colour {r,g,b} |
| in_alpha | input | CW | Alpha, 0 is fully transparent |
| in_blend | input | 1 | 1 = alpha test and blend, 0 = opaque |
| tex_rgb | input | 3*CW | Filtered texel colour, same cycle as fragment |
| z_rd_en | output | 1 | Depth read strobe |
| z_rd_addr | output | XW+YW | Depth read address |
| z_rd_data | input | ZW | Depth read data, one cycle after strobe |
| z_wr_en | output | 1 | Depth write strobe |
| z_wr_addr | output | XW+YW | Depth write address |
| z_wr_data | output | ZW | Depth write data |
| c_rd_en | output | 1 | Colour read strobe |
| c_rd_addr | output | XW+YW | Colour read address |
| c_rd_data | input | 3*CW | Colour read data, one cycle after strobe |
| c_wr_en | output | 1 | Colour write strobe |
| c_wr_addr | output | XW+YW | Colour write address |
| c_wr_data | output | 3*CW | Colour write data |

## Verification
Three kinds of event can share a cycle: accepting a new fragment, with its depth read, and the pending depth or colour write of an older fragment. They are only harmful when both target the same pixel, because the new read would then see the old value. The bench provokes this by offering fragments for one pixel back to back. It judges the outcome in two ways. It measures the gap between accept cycles, which must be four. It also reads the final depth and colour memory, where a three-fragment sequence must leave the nearest fragment's values.

// File: rtl/frag_pkg.sv
package frag_pkg;
    typedef enum logic [1:0] {
        FATE_NONE   = 2'd0,
        FATE_OPAQUE = 2'd1,
        FATE_BLEND  = 2'd2
    } fate_e;
endpackage

// File: rtl/frag_modulate.sv
module frag_modulate #(
    parameter int CW = 8
) (
    input  logic [3*CW-1:0] base_rgb,
    input  logic [3*CW-1:0] texel_rgb,
    output logic [3*CW-1:0] out_rgb
);
    localparam int SW = 2*CW + 1;
    localparam int MAXV = (1 << CW) - 1;
    localparam logic [SW-1:0] HALF_S = SW'(MAXV / 2);
    localparam logic [SW-1:0] MAX_S  = SW'(MAXV);

    for (genvar ch = 0; ch < 3; ch++) begin : g_ch
        logic [SW-1:0] prod;
        logic [SW-1:0] quo;
        always_comb begin
            prod = SW'(base_rgb[ch*CW +: CW]) * SW'(texel_rgb[ch*CW +: CW]) + HALF_S;
            quo  = prod / MAX_S;
            out_rgb[ch*CW +: CW] = quo[CW-1:0];
        end
    end
endmodule

// File: rtl/frag_blend.sv
module frag_blend #(
    parameter int CW = 8
) (
    input  logic [3*CW-1:0] src_rgb,
    input  logic [3*CW-1:0] dst_rgb,
    input  logic [CW-1:0]   alpha,
    output logic [3*CW-1:0] out_rgb
);
    localparam int SW = 2*CW + 1;
    localparam int MAXV = (1 << CW) - 1;
    localparam logic [SW-1:0] HALF_S = SW'(MAXV / 2);
    localparam logic [SW-1:0] MAX_S  = SW'(MAXV);

    logic [SW-1:0] a_w;
    logic [SW-1:0] inv_w;
    assign a_w   = SW'(alpha);
    assign inv_w = MAX_S - a_w;

    for (genvar ch = 0; ch < 3; ch++) begin : g_ch
        logic [SW-1:0] acc;
        logic [SW-1:0] quo;
        always_comb begin
            acc = SW'(src_rgb[ch*CW +: CW]) * a_w
                + SW'(dst_rgb[ch*CW +: CW]) * inv_w + HALF_S;
            quo = acc / MAX_S;
            out_rgb[ch*CW +: CW] = quo[CW-1:0];
        end
    end
endmodule

// File: rtl/frag_hazard.sv
module frag_hazard #(
    parameter int AW    = 8,
    parameter int SLOTS = 3
) (
    input  logic [SLOTS-1:0]    busy,
    input  logic [SLOTS*AW-1:0] addrs,
    input  logic [AW-1:0]       probe,
    output logic                hit
);
    logic [SLOTS-1:0] match;
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign match[s] = busy[s] && (addrs[s*AW +: AW] == probe);
    end
    assign hit = |match;
endmodule

// File: rtl/frag_backend.sv
module frag_backend
    import frag_pkg::*;
#(
    parameter int XW = 4,
    parameter int YW = 4,
    parameter int ZW = 16,
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [XW-1:0]        in_x,
    input  logic [YW-1:0]        in_y,
    input  logic [ZW-1:0]        in_z,
    input  logic [3*CW-1:0]      in_rgb,
    input  logic [CW-1:0]        in_alpha,
    input  logic                 in_blend,
    input  logic [3*CW-1:0]      tex_rgb,
    output logic                 z_rd_en,
    output logic [XW+YW-1:0]     z_rd_addr,
    input  logic [ZW-1:0]        z_rd_data,
    output logic                 z_wr_en,
    output logic [XW+YW-1:0]     z_wr_addr,
    output logic [ZW-1:0]        z_wr_data,
    output logic                 c_rd_en,
    output logic [XW+YW-1:0]     c_rd_addr,
    input  logic [3*CW-1:0]      c_rd_data,
    output logic                 c_wr_en,
    output logic [XW+YW-1:0]     c_wr_addr,
    output logic [3*CW-1:0]      c_wr_data
);
    localparam int AW = XW + YW;
    localparam int PW = 3 * CW;
    localparam int SLOTS = 3;

    // Z stage
    logic          v1;
    logic [AW-1:0] a1;
    logic [ZW-1:0] z1;
    logic [PW-1:0] rgb1;
    logic [PW-1:0] tex1;
    logic [CW-1:0] alpha1;
    logic          blend1;
    // shade stage
    logic          v2;
    logic [AW-1:0] a2;
    logic [PW-1:0] shade2;
    logic [CW-1:0] alpha2;
    logic          blend2;
    // write stage
    fate_e         fate3;
    logic [AW-1:0] a3;
    logic [PW-1:0] shade3;
    logic [CW-1:0] alpha3;

    logic [AW-1:0] in_addr;
    logic          accept;
    logic          hit;
    logic          z_pass;
    logic          s2_keep;
    logic [PW-1:0] shade1;
    logic [PW-1:0] mixed;
    logic [SLOTS-1:0] busy_v;

    assign in_addr = {in_y, in_x};
    assign busy_v  = {fate3 != FATE_NONE, v2, v1};

    frag_hazard #(.AW(AW), .SLOTS(SLOTS)) u_hz (
        .busy  (busy_v),
        .addrs ({a3, a2, a1}),
        .probe (in_addr),
        .hit   (hit)
    );

    frag_modulate #(.CW(CW)) u_mod (
        .base_rgb  (rgb1),
        .texel_rgb (tex1),
        .out_rgb   (shade1)
    );

    frag_blend #(.CW(CW)) u_mix (
        .src_rgb (shade3),
        .dst_rgb (c_rd_data),
        .alpha   (alpha3),
        .out_rgb (mixed)
    );

    assign in_ready = !hit;
    assign accept   = in_valid && in_ready;
    assign z_pass   = v1 && (z1 < z_rd_data);
    assign s2_keep  = v2 && !(blend2 && (alpha2 == '0));

    // stage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1     <= 1'b0;
            v2     <= 1'b0;
            fate3  <= FATE_NONE;
            a1     <= '0;
            z1     <= '0;
            rgb1   <= '0;
            tex1   <= '0;
            alpha1 <= '0;
            blend1 <= 1'b0;
            a2     <= '0;
            shade2 <= '0;
            alpha2 <= '0;
            blend2 <= 1'b0;
            a3     <= '0;
            shade3 <= '0;
            alpha3 <= '0;
        end else begin
            v1 <= accept;
            if (accept) begin
                a1     <= in_addr;
                z1     <= in_z;
                rgb1   <= in_rgb;
                tex1   <= tex_rgb;
                alpha1 <= in_alpha;
                blend1 <= in_blend;
            end
            v2 <= z_pass;
            if (z_pass) begin
                a2     <= a1;
                shade2 <= shade1;
                alpha2 <= alpha1;
                blend2 <= blend1;
            end
            if (s2_keep) begin
                fate3  <= blend2 ? FATE_BLEND : FATE_OPAQUE;
                a3     <= a2;
                shade3 <= shade2;
                alpha3 <= alpha2;
            end else begin
                fate3  <= FATE_NONE;
            end
        end
    end

    // memory port drive
    always_comb begin
        z_rd_en   = accept;
        z_rd_addr = in_addr;
        z_wr_en   = z_pass;
        z_wr_addr = a1;
        z_wr_data = z1;
        c_rd_en   = s2_keep && blend2;
        c_rd_addr = a2;
        c_wr_addr = a3;
        unique case (fate3)
            FATE_NONE: begin
                c_wr_en   = 1'b0;
                c_wr_data = shade3;
            end
            FATE_OPAQUE: begin
                c_wr_en   = 1'b1;
                c_wr_data = shade3;
            end
            FATE_BLEND: begin
                c_wr_en   = 1'b1;
                c_wr_data = mixed;
            end
            default: begin
                c_wr_en   = 1'b0;
                c_wr_data = shade3;
            end
        endcase
    end
endmodule

// File: rtl/frag_backend_chk.sv
module frag_backend_chk #(
    parameter int XW = 4,
    parameter int YW = 4,
    parameter int ZW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic [XW-1:0]      in_x,
    input logic [YW-1:0]      in_y,
    input logic               z_rd_en,
    input logic [XW+YW-1:0]   z_rd_addr,
    input logic [ZW-1:0]      z_rd_data,
    input logic               z_wr_en,
    input logic [XW+YW-1:0]   z_wr_addr,
    input logic [ZW-1:0]      z_wr_data,
    input logic               c_rd_en,
    input logic [XW+YW-1:0]   c_rd_addr,
    input logic               c_wr_en,
    input logic [XW+YW-1:0]   c_wr_addr
);
    a_r2_zwr_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        z_wr_en |-> ($past(z_rd_en) && z_wr_addr == $past(z_rd_addr)));

    a_r3_zwr_only_nearer: assert property (@(posedge clk) disable iff (!rst_n)
        z_wr_en |-> (z_wr_data < z_rd_data));

    a_r5_cwr_after_zwr: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr_en |-> ($past(z_wr_en, 2) && c_wr_addr == $past(z_wr_addr, 2)));

    a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        c_rd_en |=> (c_wr_en && c_wr_addr == $past(c_rd_addr)));

    a_r8_stall_on_zwr: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && z_wr_en && {in_y, in_x} == z_wr_addr) |-> !in_ready);

    a_r8_stall_on_cwr: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && c_wr_en && {in_y, in_x} == c_wr_addr) |-> !in_ready);
endmodule

bind frag_backend frag_backend_chk #(.XW(XW), .YW(YW), .ZW(ZW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_x      (in_x),
    .in_y      (in_y),
    .z_rd_en   (z_rd_en),
    .z_rd_addr (z_rd_addr),
    .z_rd_data (z_rd_data),
    .z_wr_en   (z_wr_en),
    .z_wr_addr (z_wr_addr),
    .z_wr_data (z_wr_data),
    .c_rd_en   (c_rd_en),
    .c_rd_addr (c_rd_addr),
    .c_wr_en   (c_wr_en),
    .c_wr_addr (c_wr_addr)
);

// File: tb/sim_frag_backend.sv
module sim_frag_backend;
    localparam int XW = 4, YW = 4, ZW = 16, CW = 8;
    localparam int AW = XW + YW;
    localparam int PW = 3 * CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [XW-1:0] in_x = '0;
    logic [YW-1:0] in_y = '0;
    logic [ZW-1:0] in_z = '0;
    logic [PW-1:0] in_rgb = '0;
    logic [CW-1:0] in_alpha = '0;
    logic in_blend = 1'b0;
    logic [PW-1:0] tex_rgb = '0;
    logic z_rd_en, z_wr_en, c_rd_en, c_wr_en;
    logic [AW-1:0] z_rd_addr, z_wr_addr, c_rd_addr, c_wr_addr;
    logic [ZW-1:0] z_rd_data = '0;
    logic [ZW-1:0] z_wr_data;
    logic [PW-1:0] c_rd_data = '0;
    logic [PW-1:0] c_wr_data;

    logic [ZW-1:0] zmem [0:(1<<AW)-1];
    logic [PW-1:0] cmem [0:(1<<AW)-1];
    int cyc = 0, last_acc = 0, prev_acc = 0, last_zw = 0, last_cw = 0;
    int zw_cnt = 0, cw_cnt = 0, cr_cnt = 0;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    frag_backend #(.XW(XW), .YW(YW), .ZW(ZW), .CW(CW)) u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (z_rd_en) z_rd_data <= zmem[z_rd_addr];
        if (z_wr_en) begin zmem[z_wr_addr] <= z_wr_data; zw_cnt <= zw_cnt + 1; last_zw <= cyc; end
        if (c_rd_en) begin c_rd_data <= cmem[c_rd_addr]; cr_cnt <= cr_cnt + 1; end
        if (c_wr_en) begin cmem[c_wr_addr] <= c_wr_data; cw_cnt <= cw_cnt + 1; last_cw <= cyc; end
        if (in_valid && in_ready) begin prev_acc <= last_acc; last_acc <= cyc; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int x, input int y, input int z, input logic [PW-1:0] rgb,
                        input int a, input logic bl, input logic [PW-1:0] tex);
        @(negedge clk);
        in_x = XW'(x); in_y = YW'(y); in_z = ZW'(z); in_rgb = rgb;
        in_alpha = CW'(a); in_blend = bl; tex_rgb = tex; in_valid = 1'b1;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    function automatic int px(input int x, input int y);
        return y * (1 << XW) + x;
    endfunction

    task automatic t_reset();
        chk("R1 ready after reset", 32'(in_ready), 1);
        chk("R1 no depth write", 32'(zw_cnt), 0);
        chk("R1 no colour write", 32'(cw_cnt), 0);
    endtask

    task automatic t_opaque();
        int cr0;
        zmem[px(2,3)] = 16'd1000; cmem[px(2,3)] = '0; cr0 = cr_cnt;
        send(2, 3, 500, {8'd200, 8'd100, 8'd50}, 0, 1'b0, {8'd255, 8'd128, 8'd0});
        settle();
        chk("R2 depth written", 32'(zmem[px(2,3)]), 500);
        chk("R2 depth write one cycle after accept", 32'(last_zw - last_acc), 1);
        chk("R4 modulated colour", 32'(cmem[px(2,3)]), {8'd0, 8'd200, 8'd50, 8'd0});
        chk("R5 colour write three cycles after accept", 32'(last_cw - last_acc), 3);
        chk("R5 no colour read when opaque", 32'(cr_cnt - cr0), 0);
    endtask

    task automatic t_depth_fail();
        int zw0, cw0;
        zmem[px(5,5)] = 16'd700; cmem[px(5,5)] = 24'h123456;
        zw0 = zw_cnt; cw0 = cw_cnt;
        send(5, 5, 700, 24'hFFFFFF, 255, 1'b0, 24'hFFFFFF);
        send(5, 5, 800, 24'hFFFFFF, 255, 1'b1, 24'hFFFFFF);
        settle();
        chk("R3 equal/farther no depth write", 32'(zw_cnt - zw0), 0);
        chk("R3 equal/farther no colour write", 32'(cw_cnt - cw0), 0);
        chk("R3 depth unchanged", 32'(zmem[px(5,5)]), 700);
        chk("R3 colour unchanged", 32'(cmem[px(5,5)]), 32'h123456);
    endtask

    task automatic t_alpha_zero();
        int cw0;
        zmem[px(7,1)] = 16'd1000; cmem[px(7,1)] = 24'h0A0B0C; cw0 = cw_cnt;
        send(7, 1, 10, 24'hFFFFFF, 0, 1'b1, 24'hFFFFFF);
        settle();
        chk("R6 depth still written", 32'(zmem[px(7,1)]), 10);
        chk("R6 no colour write", 32'(cw_cnt - cw0), 0);
        chk("R6 colour unchanged", 32'(cmem[px(7,1)]), 32'h0A0B0C);
    endtask

    task automatic t_blend();
        zmem[px(9,9)] = 16'd1000; cmem[px(9,9)] = {8'd0, 8'd255, 8'd100};
        send(9, 9, 20, 24'hFFFFFF, 128, 1'b1, 24'hFFFFFF);
        settle();
        chk("R7 half blend", 32'(cmem[px(9,9)]), {8'd0, 8'd128, 8'd255, 8'd178});
        send(9, 9, 10, {8'd10, 8'd20, 8'd30}, 255, 1'b1, 24'hFFFFFF);
        settle();
        chk("R7 full alpha takes source", 32'(cmem[px(9,9)]), {8'd0, 8'd10, 8'd20, 8'd30});
    endtask

    task automatic t_stream();
        int first, cw0;
        cw0 = cw_cnt;
        for (int i = 1; i <= 4; i++) zmem[px(i,12)] = 16'd900;
        send(1, 12, 5, 24'h010101, 0, 1'b0, 24'hFFFFFF);
        first = last_acc;
        for (int i = 2; i <= 4; i++) send(i, 12, 5, 24'h010101 * i, 0, 1'b0, 24'hFFFFFF);
        chk("R8 distinct pixels one per clock", 32'(last_acc - first), 3);
        settle();
        chk("R9 every fragment written once", 32'(cw_cnt - cw0), 4);
        chk("R9 last stream pixel", 32'(cmem[px(4,12)]), 32'h040404);
    endtask

    task automatic t_same_pixel();
        zmem[px(6,14)] = 16'd1000;
        send(6, 14, 300, 24'h111111, 0, 1'b0, 24'hFFFFFF);
        send(6, 14, 200, 24'h222222, 0, 1'b0, 24'hFFFFFF);
        chk("R8 same-pixel follower waits four cycles", 32'(last_acc - prev_acc), 4);
        send(6, 14, 250, 24'h333333, 0, 1'b0, 24'hFFFFFF);
        settle();
        chk("R9 nearest depth kept", 32'(zmem[px(6,14)]), 200);
        chk("R9 nearest colour kept", 32'(cmem[px(6,14)]), 32'h222222);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) begin zmem[i] = '1; cmem[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        t_reset();
        t_opaque();
        t_depth_fail();
        t_alpha_zero();
        t_blend();
        t_stream();
        t_same_pixel();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule